// File: doc/BRIEF.md
# Two-Cycle Processor Bus Master

This block sits between a processor core and a shared system bus. It turns one core request into one bus transfer: a read or a write to memory or to an I/O port. A request carries an address, write data, a direction flag and a space select. The block hands back the read data together with a one-clock completion pulse.

Every transfer takes exactly two bus clocks. In the first clock the address goes out (for a write, the data goes out as well) and no strobe is active, which gives the slave time to decode the address. In the second clock the read or write strobe is active. On a read, the data lines are sampled at the edge that closes that clock. After that edge the address, the data drive and the strobe are all released together. A parameter sets the strobe polarity. A second parameter selects isolated I/O, where a separate space line tells I/O accesses from memory accesses so the two spaces can use the same addresses, or memory-mapped I/O, where that line stays low.

Top module: `cpu_bus_master`

## Requirements
- R1: The clock after a request is accepted is the setup cycle. `bus_addr` shows the request address, and for a write `bus_wdata` shows the write data with `bus_wdata_oe`=1. Neither strobe is active in this cycle.
- R2: For a read, the clock after the setup cycle is the strobe cycle. The read strobe is active only in that cycle, and `bus_addr` keeps the same address.
- R3: A read captures `bus_rdata` at the clock edge that ends the strobe cycle. The captured value appears on `rsp_rdata` while `rsp_done`=1 and stays unchanged afterwards, whatever `bus_rdata` does.
- R4: For a write, the write strobe is active only in the second cycle. `bus_wdata` and `bus_wdata_oe`=1 are held through both cycles, with the address unchanged.
- R5: In the clock after the strobe cycle, `rsp_done` is 1 for exactly one clock. In that clock `bus_addr` is 0, `bus_wdata_oe` is 0 and both strobes are inactive.
- R6: `bus_wdata_oe` is 0 in every read cycle and whenever no transfer is in progress.
- R7: With ISOLATED_IO=1, `bus_io` is 1 in both cycles of an access with `req_io`=1, and 0 for memory accesses and when idle. With ISOLATED_IO=0, `bus_io` is always 0.
- R8: With ACTIVE_HIGH=1 an active strobe is 1 and an inactive strobe is 0. With ACTIVE_HIGH=0 the levels are inverted, so an inactive strobe is 1.
- R9: A request made during the setup or strobe cycle has no effect. The transfer in progress keeps its address, and no new transfer follows it.
- R10: A request made while `rsp_done`=1 is accepted. Its setup cycle is the next clock.
- R11: A synchronous reset returns the block to idle. Both strobes become inactive, `bus_addr` becomes 0, `bus_wdata_oe` becomes 0 and `rsp_done` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Core requests a transfer |
| req_addr | input | ADDR_W | Transfer address |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| rsp_rdata | output | DATA_W | Last captured read data |
| rsp_done | output | 1 | One-clock completion pulse |
| bus_addr | output | ADDR_W | Address lines, driven only during a transfer |
| bus_wdata | output | DATA_W | Outgoing data lines |
| bus_wdata_oe | output | 1 | Drive enable for the outgoing data |
| bus_rdata | input | DATA_W | Incoming data lines |
| bus_rd | output | 1 | Read strobe, polarity set by ACTIVE_HIGH |
| bus_wr | output | 1 | Write strobe, polarity set by ACTIVE_HIGH |
| bus_io | output | 1 | Space select, 1 = I/O access |

## Verification
The assertions assume a synchronous core. Request fields change only between clock edges and settle before the edge that samples them, and reset is held from time zero through at least one edge. They make no assumption about when requests arrive, because the block has to ignore requests made while it is busy. The bench changes every input at the falling edge, including requests made mid-transfer and a reset in the middle of a cycle. It changes `bus_rdata` before, during and after the strobe cycle, which shows exactly which edge does the capture.

// File: rtl/cpu_bus_pkg.sv
package cpu_bus_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_DONE   = 2'd3
    } phase_e;
endpackage

// File: rtl/cpu_bus_seq.sv
module cpu_bus_seq
    import cpu_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [DATA_W-1:0] bus_rdata,
    output phase_e            phase_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o,
    output logic              write_o,
    output logic              io_o,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        phase_e            ph;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              io;
        logic [DATA_W-1:0] rdata;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic    can_accept;

    assign can_accept = (st_q.ph == PH_IDLE) || (st_q.ph == PH_DONE);

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_IDLE, PH_DONE: begin
                if (req_valid) begin
                    st_d.ph    = PH_SETUP;
                    st_d.addr  = req_addr;
                    st_d.wdata = req_wdata;
                    st_d.write = req_write;
                    st_d.io    = req_io;
                end else begin
                    st_d.ph = PH_IDLE;
                end
            end
            PH_SETUP:  st_d.ph = PH_STROBE;
            PH_STROBE: begin
                st_d.ph = PH_DONE;
                if (!st_q.write) st_d.rdata = bus_rdata;
            end
            default:   st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.ph;
    assign addr_o  = st_q.addr;
    assign wdata_o = st_q.wdata;
    assign write_o = st_q.write;
    assign io_o    = st_q.io;
    assign rdata_o = st_q.rdata;

    // R9
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph == PH_SETUP) |=> (st_q.ph == PH_STROBE) && $stable(st_q.addr) && $stable(st_q.write));

    // R5
    done_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.ph == PH_STROBE) |=> (st_q.ph == PH_DONE));

    // R10
    done_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (can_accept && req_valid) |=> (st_q.ph == PH_SETUP));
endmodule

// File: rtl/cpu_bus_drive.sv
module cpu_bus_drive
    import cpu_bus_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter bit ACTIVE_HIGH = 1'b1,
    parameter bit ISOLATED_IO = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              write_i,
    input  logic              io_i,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_io,
    output logic              done_o
);
    localparam logic INACTIVE_LVL = ACTIVE_HIGH ? 1'b0 : 1'b1;

    logic in_cycle, strobe_ph, rd_on, wr_on;

    assign in_cycle  = (phase_i == PH_SETUP) || (phase_i == PH_STROBE);
    assign strobe_ph = (phase_i == PH_STROBE);
    assign rd_on     = strobe_ph && !write_i;
    assign wr_on     = strobe_ph && write_i;

    assign bus_addr     = in_cycle ? addr_i : '0;
    assign bus_wdata_oe = in_cycle && write_i;
    assign bus_wdata    = bus_wdata_oe ? wdata_i : '0;
    assign bus_rd       = rd_on ^ INACTIVE_LVL;
    assign bus_wr       = wr_on ^ INACTIVE_LVL;
    assign done_o       = (phase_i == PH_DONE);

    generate
        if (ISOLATED_IO) begin : g_isolated
            assign bus_io = in_cycle && io_i;
        end else begin : g_mapped
            assign bus_io = 1'b0;
        end
    endgenerate

    // R6
    oe_read_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd != INACTIVE_LVL) |-> !bus_wdata_oe);

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !((bus_rd != INACTIVE_LVL) && (bus_wr != INACTIVE_LVL)));
endmodule

// File: rtl/cpu_bus_master.sv
module cpu_bus_master
    import cpu_bus_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter bit ACTIVE_HIGH = 1'b1,
    parameter bit ISOLATED_IO = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_write,
    input  logic              req_io,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wdata_oe,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              bus_io
);
    phase_e            phase;
    logic [ADDR_W-1:0] addr_r;
    logic [DATA_W-1:0] wdata_r;
    logic              write_r, io_r;

    cpu_bus_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .bus_rdata(bus_rdata), .phase_o(phase), .addr_o(addr_r),
        .wdata_o(wdata_r), .write_o(write_r), .io_o(io_r), .rdata_o(rsp_rdata)
    );

    cpu_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                    .ACTIVE_HIGH(ACTIVE_HIGH), .ISOLATED_IO(ISOLATED_IO)) u_drive (
        .clk(clk), .rst(rst), .phase_i(phase), .addr_i(addr_r), .wdata_i(wdata_r),
        .write_i(write_r), .io_i(io_r), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wdata_oe(bus_wdata_oe), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_io(bus_io), .done_o(rsp_done)
    );

    logic rd_act, wr_act;
    assign rd_act = ACTIVE_HIGH ? bus_rd : !bus_rd;
    assign wr_act = ACTIVE_HIGH ? bus_wr : !bus_wr;

    // R2
    rd_addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        rd_act |-> $stable(bus_addr) && !$past(rd_act));

    // R2
    rd_single_chk: assert property (@(posedge clk) disable iff (rst)
        rd_act |=> !rd_act);

    // R4
    wr_data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        wr_act |-> $past(bus_wdata_oe) && $stable(bus_wdata) && $stable(bus_addr));

    // R5
    done_release_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(rd_act || wr_act) && (bus_addr == '0) && !bus_wdata_oe);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> !rd_act && !wr_act && !bus_wdata_oe && !rsp_done);
endmodule

// File: tb/cpu_bus_master_tb.sv
module cpu_bus_master_tb;
    localparam int AW = 16;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_write = 1'b0;
    logic          req_io = 1'b0;
    logic [DW-1:0] bus_rdata = '0;

    logic [DW-1:0] rsp_rdata, a_rsp_rdata;
    logic          rsp_done, a_rsp_done;
    logic [AW-1:0] bus_addr, a_bus_addr;
    logic [DW-1:0] bus_wdata, a_bus_wdata;
    logic          bus_wdata_oe, a_bus_wdata_oe;
    logic          bus_rd, bus_wr, bus_io, a_bus_rd, a_bus_wr, a_bus_io;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cpu_bus_master #(.ADDR_W(AW), .DATA_W(DW), .ACTIVE_HIGH(1'b1), .ISOLATED_IO(1'b1)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_wdata_oe(bus_wdata_oe), .bus_rdata(bus_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io)
    );

    cpu_bus_master #(.ADDR_W(AW), .DATA_W(DW), .ACTIVE_HIGH(1'b0), .ISOLATED_IO(1'b0)) u_dut_alt (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .rsp_rdata(a_rsp_rdata), .rsp_done(a_rsp_done), .bus_addr(a_bus_addr),
        .bus_wdata(a_bus_wdata), .bus_wdata_oe(a_bus_wdata_oe), .bus_rdata(bus_rdata),
        .bus_rd(a_bus_rd), .bus_wr(a_bus_wr), .bus_io(a_bus_io)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        chk(bus_addr == '0, "R11 addr", 32'(bus_addr), 0);
        chk(!bus_rd && !bus_wr, "R11 strobes", {bus_rd, bus_wr}, 0);
        chk(!bus_wdata_oe && !rsp_done, "R11 oe/done", {bus_wdata_oe, rsp_done}, 0);
        chk(a_bus_rd && a_bus_wr, "R8 alt idle level", {a_bus_rd, a_bus_wr}, 3);
    endtask

    task automatic t_read(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic io);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = 1'b0; req_io = io; bus_rdata = ~d;
        @(negedge clk); // setup cycle
        req_valid = 1'b0;
        chk(bus_addr == a, "R1 read addr", 32'(bus_addr), 32'(a));
        chk(!bus_rd && !bus_wr, "R1 no strobe", {bus_rd, bus_wr}, 0);
        chk(!bus_wdata_oe, "R6 oe setup", 32'(bus_wdata_oe), 0);
        chk(bus_io == io, "R7 io setup", 32'(bus_io), 32'(io));
        chk(a_bus_io == 1'b0, "R7 mapped io", 32'(a_bus_io), 0);
        bus_rdata = d;
        @(negedge clk); // strobe cycle
        chk(bus_rd && !bus_wr, "R2 read strobe", {bus_rd, bus_wr}, 2);
        chk(bus_addr == a, "R2 addr held", 32'(bus_addr), 32'(a));
        chk(!a_bus_rd && a_bus_wr, "R8 alt read low", {a_bus_rd, a_bus_wr}, 1);
        chk(!bus_wdata_oe, "R6 oe strobe", 32'(bus_wdata_oe), 0);
        chk(bus_io == io, "R7 io strobe", 32'(bus_io), 32'(io));
        @(negedge clk); // done cycle
        bus_rdata = 8'h5A ^ d;
        chk(rsp_done, "R5 done", 32'(rsp_done), 1);
        chk(rsp_rdata == d, "R3 rdata", 32'(rsp_rdata), 32'(d));
        chk(a_rsp_rdata == d, "R3 alt rdata", 32'(a_rsp_rdata), 32'(d));
        chk(bus_addr == '0 && !bus_rd && !bus_io, "R5 release", {bus_addr, bus_rd, bus_io}, 0);
        @(negedge clk);
        chk(!rsp_done, "R5 pulse width", 32'(rsp_done), 0);
        chk(rsp_rdata == d, "R3 rdata held", 32'(rsp_rdata), 32'(d));
    endtask

    task automatic t_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic io);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_wdata = d; req_write = 1'b1; req_io = io;
        @(negedge clk);
        req_valid = 1'b0; req_wdata = ~d;
        chk(bus_addr == a && bus_wdata == d, "R1 write setup", {bus_addr, bus_wdata}, {a, d});
        chk(bus_wdata_oe && !bus_wr && !bus_rd, "R1 write no strobe", {bus_wdata_oe, bus_wr, bus_rd}, 4);
        chk(bus_io == io, "R7 write io", 32'(bus_io), 32'(io));
        @(negedge clk);
        chk(bus_wr && !bus_rd, "R4 write strobe", {bus_wr, bus_rd}, 2);
        chk(bus_wdata_oe && bus_wdata == d && bus_addr == a, "R4 write hold", {bus_wdata, bus_addr}, {d, a});
        chk(!a_bus_wr, "R8 alt write low", 32'(a_bus_wr), 0);
        @(negedge clk);
        chk(rsp_done && !bus_wdata_oe && !bus_wr, "R5 write done", {rsp_done, bus_wdata_oe, bus_wr}, 4);
        @(negedge clk);
        chk(!bus_wdata_oe && bus_addr == '0, "R6 idle oe", {bus_wdata_oe, bus_addr}, 0);
    endtask

    task automatic t_busy_ignore();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h1111; req_write = 1'b0; req_io = 1'b0; bus_rdata = 8'h3C;
        @(negedge clk); // setup; new request offered while busy
        req_addr = 16'h2222; req_write = 1'b1;
        @(negedge clk); // strobe
        chk(bus_addr == 16'h1111 && bus_rd && !bus_wr, "R9 busy addr", 32'(bus_addr), 32'h1111);
        req_valid = 1'b0;
        @(negedge clk); // done
        chk(rsp_done, "R9 done", 32'(rsp_done), 1);
        @(negedge clk);
        chk(bus_addr == '0 && !bus_wdata_oe, "R9 no second transfer", 32'(bus_addr), 0);
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0404; req_write = 1'b0; req_io = 1'b1; bus_rdata = 8'h77;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        @(negedge clk); // done
        chk(rsp_done && rsp_rdata == 8'h77, "R10 first done", 32'(rsp_rdata), 32'h77);
        req_valid = 1'b1; req_addr = 16'h0404; req_wdata = 8'hE1; req_write = 1'b1; req_io = 1'b0;
        @(negedge clk); // setup of second
        req_valid = 1'b0;
        chk(bus_addr == 16'h0404 && bus_wdata_oe && bus_wdata == 8'hE1 && !bus_io,
            "R10 next setup", {bus_addr, bus_wdata}, {16'h0404, 8'hE1});
        @(negedge clk);
        chk(bus_wr, "R10 next strobe", 32'(bus_wr), 1);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_mid_reset();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0BAD; req_wdata = 8'h99; req_write = 1'b1; req_io = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(!bus_wr && !bus_rd && !bus_wdata_oe && bus_addr == '0 && !rsp_done && !bus_io,
            "R11 mid reset", {bus_wr, bus_wdata_oe, bus_addr}, 0);
        chk(a_bus_wr && a_bus_rd, "R11 alt strobes", {a_bus_wr, a_bus_rd}, 3);
        @(negedge clk);
        chk(bus_addr == '0 && !rsp_done, "R11 stays idle", 32'(bus_addr), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_read(16'h1234, 8'hA5, 1'b0);
        t_read(16'h1234, 8'h3E, 1'b1);
        t_write(16'h00FF, 8'hC3, 1'b0);
        t_write(16'h8001, 8'h18, 1'b1);
        t_busy_ignore();
        t_back_to_back();
        t_mid_reset();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule